// File: doc/BRIEF.md
# Link Receive-Silence Watchdog

This block guards the receive side of a serial point-to-point link against a stalled partner. While the link sits in one of its two active power states (full-power L0 or standby L0s), a timer counts clock cycles. Every received data link layer packet (DLLP) of any kind restarts the count from zero. If the count reaches a limit equal to the 200 µs minimum, the block raises a retrain request toward the link training state machine, asking it to move the link into its recovery state.

The request is held until the training state machine acknowledges it, or until the link leaves the active states. In either case the timer is cleared. Outside the active states the timer is cleared and stays at zero. When the link enters an active state again, counting starts over from zero. A sticky status flag records that a timeout happened. A write-one-to-clear input clears the flag.

The limit is `CLK_MHZ * TIMEOUT_US` cycles. The defaults are a 200 MHz clock and a 200 µs limit, giving 40000 cycles. An expiry therefore lands at exactly 200 µs, which is inside the allowed window of 200 µs to 300 µs.

Top module: `fc_silence_watchdog`

## Requirements
- R1: After reset, `retrain_req` and `timeout_sts` are 0.
- R2: The timer is armed only when `link_state` is 3'd1 (L0) or 3'd2 (L0s). For any other code, `retrain_req` stays 0 and the timer is held at zero.
- R3: In L0, with no DLLP, `retrain_req` rises on the LIMIT-th rising clock edge after the link enters the state, and not earlier. LIMIT = CLK_MHZ*TIMEOUT_US.
- R4: A cycle with `dllp_rcvd` high resets the count to zero at that cycle's edge. The next expiry comes LIMIT edges after that edge. This holds even when the pulse falls in the last cycle before expiry.
- R5: Once raised, `retrain_req` stays high while `retrain_ack` is low and the link stays armed. `dllp_rcvd` has no effect on it during this time.
- R6: `retrain_ack` high while `retrain_req` is high drops the request at that edge. Counting then restarts from zero, so the next request comes LIMIT edges later.
- R7: When the link leaves L0/L0s, `retrain_req` drops and the count clears at the next edge. On re-entry, expiry takes a full LIMIT edges again.
- R8: `timeout_sts` is set at the edge where a request is raised. It stays set after the request ends.
- R9: `timeout_clr` high clears `timeout_sts` at the next edge. If an expiry occurs in the same cycle, the set wins.
- R10: L0s (code 3'd2) arms the timer with the same limit as L0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_state | input | 3 | Current link power state code (1 = L0, 2 = L0s) |
| dllp_rcvd | input | 1 | One-cycle pulse per DLLP received |
| retrain_ack | input | 1 | Training state machine accepts the retrain request |
| timeout_clr | input | 1 | Write-one-to-clear for the timeout status |
| retrain_req | output | 1 | Request to enter link recovery |
| timeout_sts | output | 1 | Sticky flag: a timeout occurred |

## Verification
The timer is driven with uninterrupted silence in L0 and in L0s, and the request is sampled one edge before and at the LIMIT-th edge. This separates an exact count from an off-by-one. A DLLP placed in the final cycle before expiry shows whether a packet restarts the count or is lost against the expiry. Short stays in an active state, and the unarmed codes held for longer than LIMIT, show whether leaving the active states truly clears the timer. The acknowledge and clear inputs are timed against an expiry to show that the request holds until it is accepted and that a set of the status flag beats a clear in the same cycle.

// File: rtl/fcw_pkg.sv
package fcw_pkg;
    typedef enum logic [2:0] {
        LS_DOWN  = 3'd0,
        LS_L0    = 3'd1,
        LS_L0S   = 3'd2,
        LS_L1    = 3'd3,
        LS_L2    = 3'd4,
        LS_RECOV = 3'd5,
        LS_CFG   = 3'd6,
        LS_DIS   = 3'd7
    } link_state_e;

    function automatic logic is_active_state(input logic [2:0] code);
        return (code == LS_L0) || (code == LS_L0S);
    endfunction
endpackage

// File: rtl/fcw_arm_decode.sv
module fcw_arm_decode
    import fcw_pkg::*;
(
    input  logic [2:0] link_state,
    output logic       armed
);
    always_comb begin
        armed = is_active_state(link_state);
    end
endmodule

// File: rtl/fcw_timer.sv
module fcw_timer #(
    parameter int unsigned LIMIT = 40000,
    localparam int unsigned CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic hold,
    input  logic kick,
    output logic expire
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    tmr_s st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (!armed || hold || kick) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            expire   = 1'b1;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the count never passes the limit
    assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);
    // R7: an unarmed cycle leaves the timer at zero
    assert_clear_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> st_q.cnt == '0);
    // R4: a kick restarts from zero
    assert_kick_restarts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> st_q.cnt == '0);
endmodule

// File: rtl/fcw_retrain_ctrl.sv
module fcw_retrain_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic expire,
    input  logic ack,
    input  logic clr,
    output logic req,
    output logic sts
);
    typedef struct packed {
        logic req;
        logic sts;
    } ctl_s;

    ctl_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!armed) begin
            st_d.req = 1'b0;
        end else if (st_q.req && ack) begin
            st_d.req = 1'b0;
        end else if (expire) begin
            st_d.req = 1'b1;
        end
        if (expire)   st_d.sts = 1'b1;
        else if (clr) st_d.sts = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req = st_q.req;
    assign sts = st_q.sts;

    // R5: request holds until accepted or link leaves active states
    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && armed) |=> req);
    // R2: never a request while unarmed
    assert_no_req_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> !req);
    // R8: a fresh request comes with the status flag
    assert_sts_with_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> sts);
    // R9: clear without expiry drops the flag
    assert_clr_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !expire) |=> !sts);
endmodule

// File: rtl/fc_silence_watchdog.sv
module fc_silence_watchdog #(
    parameter int unsigned CLK_MHZ    = 200,
    parameter int unsigned TIMEOUT_US = 200,
    localparam int unsigned LIMIT = CLK_MHZ * TIMEOUT_US
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] link_state,
    input  logic       dllp_rcvd,
    input  logic       retrain_ack,
    input  logic       timeout_clr,
    output logic       retrain_req,
    output logic       timeout_sts
);
    logic armed;
    logic expire;

    fcw_arm_decode u_arm (
        .link_state (link_state),
        .armed      (armed)
    );

    fcw_timer #(.LIMIT(LIMIT)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .armed  (armed),
        .hold   (retrain_req),
        .kick   (dllp_rcvd),
        .expire (expire)
    );

    fcw_retrain_ctrl u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (armed),
        .expire(expire),
        .ack   (retrain_ack),
        .clr   (timeout_clr),
        .req   (retrain_req),
        .sts   (timeout_sts)
    );

    // R6: accepted request drops at the next edge
    assert_ack_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (retrain_req && retrain_ack) |=> !retrain_req);
    // R2: request only rises from an armed cycle
    assert_rise_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retrain_req) |-> $past(armed));
endmodule

// File: tb/fc_silence_watchdog_test.sv
module fc_silence_watchdog_test;
    localparam int unsigned CLK_MHZ = 2;
    localparam int unsigned TOUT    = 10;
    localparam int unsigned LIMIT   = CLK_MHZ * TOUT;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] link_state = 3'd0;
    logic       dllp_rcvd = 1'b0;
    logic       retrain_ack = 1'b0;
    logic       timeout_clr = 1'b0;
    logic       retrain_req;
    logic       timeout_sts;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fc_silence_watchdog #(.CLK_MHZ(CLK_MHZ), .TIMEOUT_US(TOUT)) uut (
        .clk(clk), .rst_n(rst_n), .link_state(link_state),
        .dllp_rcvd(dllp_rcvd), .retrain_ack(retrain_ack),
        .timeout_clr(timeout_clr), .retrain_req(retrain_req),
        .timeout_sts(timeout_sts)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic go_idle();
        link_state = 3'd0; dllp_rcvd = 0; retrain_ack = 0;
        timeout_clr = 1; step(1); timeout_clr = 0;
    endtask

    task automatic t_reset();
        check("R1 req after reset", retrain_req, 1'b0);
        check("R1 sts after reset", timeout_sts, 1'b0);
    endtask

    task automatic t_exact(input logic [2:0] code, input string tag);
        go_idle();
        link_state = code;
        step(LIMIT - 1);
        check({tag, " no early expiry"}, retrain_req, 1'b0);
        step(1);
        check({tag, " expiry at limit"}, retrain_req, 1'b1);
        check("R8 sts set on expiry", timeout_sts, 1'b1);
    endtask

    task automatic t_unarmed();
        go_idle();
        for (int c = 3; c < 8; c++) begin
            link_state = 3'(c);
            step(LIMIT + 3);
            check("R2 no request unarmed", retrain_req, 1'b0);
        end
        check("R2 no status unarmed", timeout_sts, 1'b0);
        link_state = 3'd1;
        step(LIMIT - 1);
        check("R2 timer held at zero while unarmed", retrain_req, 1'b0);
        step(1);
        check("R2 armed expires at limit", retrain_req, 1'b1);
    endtask

    task automatic t_dllp();
        go_idle();
        link_state = 3'd1;
        step(LIMIT - 1);
        dllp_rcvd = 1; step(1); dllp_rcvd = 0;
        check("R4 last-cycle dllp prevents expiry", retrain_req, 1'b0);
        step(LIMIT - 1);
        check("R4 no expiry before limit after dllp", retrain_req, 1'b0);
        step(1);
        check("R4 expiry limit after dllp", retrain_req, 1'b1);
    endtask

    task automatic t_hold_ack();
        go_idle();
        link_state = 3'd1;
        step(LIMIT);
        step(5);
        check("R5 request held without ack", retrain_req, 1'b1);
        dllp_rcvd = 1; step(1); dllp_rcvd = 0;
        check("R5 dllp ignored while requesting", retrain_req, 1'b1);
        retrain_ack = 1; step(1); retrain_ack = 0;
        check("R6 ack drops request", retrain_req, 1'b0);
        check("R8 sts survives ack", timeout_sts, 1'b1);
        step(LIMIT - 1);
        check("R6 restart from zero, no early", retrain_req, 1'b0);
        step(1);
        check("R6 restart expires at limit", retrain_req, 1'b1);
    endtask

    task automatic t_leave();
        go_idle();
        link_state = 3'd1;
        step(10);
        link_state = 3'd3; step(1);
        link_state = 3'd1;
        step(LIMIT - 1);
        check("R7 re-entry counts from zero", retrain_req, 1'b0);
        step(1);
        check("R7 re-entry expiry", retrain_req, 1'b1);
        link_state = 3'd5; step(1);
        check("R7 leaving drops request", retrain_req, 1'b0);
        link_state = 3'd2;
        step(LIMIT - 1);
        check("R7 no early after drop", retrain_req, 1'b0);
        step(1);
        check("R10 L0s expiry after re-entry", retrain_req, 1'b1);
    endtask

    task automatic t_status();
        go_idle();
        check("R9 clear drops status", timeout_sts, 1'b0);
        link_state = 3'd1;
        step(LIMIT - 1);
        timeout_clr = 1; step(1); timeout_clr = 0;
        check("R9 set wins over clear", timeout_sts, 1'b1);
        retrain_ack = 1; step(1); retrain_ack = 0;
        step(3);
        check("R8 sts sticky", timeout_sts, 1'b1);
        timeout_clr = 1; step(1); timeout_clr = 0;
        check("R9 clear alone", timeout_sts, 1'b0);
    endtask

    initial begin
        fork
            begin
                step(2);
                rst_n = 1'b1;
                step(1);
                t_reset();
                t_exact(3'd1, "R3");
                t_exact(3'd2, "R10");
                t_unarmed();
                t_dllp();
                t_hold_ack();
                t_leave();
                t_status();
                done = 1'b1;
            end
            begin
                repeat (20000) @(posedge clk);
                if (!done) begin
                    checks++; errors++;
                    $display("FAIL watchdog expired actual=hung expected=done");
                end
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule